// File: doc/BRIEF.md
# Serial EEPROM Sequential Read Master

This block fetches a run of consecutive bytes from a two-wire serial EEPROM whose cells are reached through an 11-bit address. The top three address bits ride inside the device-select byte, and the low eight follow as a separate byte. A host places a start address and a byte count on the inputs and pulses a start strobe. The block then does the following in order: it writes the address pointer with a write-mode select byte and no data, issues a repeated start, sends a read-mode select byte, and clocks in bytes one after another. Each byte is handed out with a single-cycle valid strobe.

The two bus lines are open-drain. The block only emits pull-down enables for the clock and data lines and samples the data line. Line changes are paced in units of a parameterised number of system clocks. The acknowledge after each sent byte is polled for a bounded number of cycles. A missing acknowledge ends the transfer with a stop condition and an error flag. When the transfer ends, a done pulse is raised. The error flag and the number of bytes delivered stay on the outputs until the next start.

Top module: `eeprom_rd_master`

## Requirements
- R1: A start condition is formed by having both lines released (high) and then pulling data low while clock stays high. A stop condition is formed by pulling data low while clock is low, then releasing clock, then releasing data. Every finished transfer with a non-zero count ends with exactly one stop.
- R2: The select byte is 0xA0 with address bits 10:8 placed in bits 3:1. Bit 0 is 0 for the pointer write and 1 for the read.
- R3: The bus order is: start, write-mode select, acknowledge, address bits 7:0, acknowledge, repeated start, read-mode select, acknowledge, then data bytes. A successful transfer shows exactly two start conditions.
- R4: Bits travel MSB first. Outside start and stop conditions, the data line changes only while clock is low. A received bit is sampled at the end of the clock-high interval.
- R5: For each acknowledge, the master releases data, raises clock and samples data for up to ACK_POLLS cycles. If data is never seen low, the transfer issues a stop and finishes with err_o = 1 and count_o = 0.
- R6: After every received byte except the last, the master drives an acknowledge (data low during one clock pulse). After the last byte it sends no acknowledge and issues the stop.
- R7: After clock rises, both lines hold for at least 2*UNIT_CLKS cycles. After clock falls or data changes, both lines hold for at least UNIT_CLKS cycles.
- R8: Each received byte appears on data_o with data_valid_o high for one cycle. Bytes come in the order of consecutive EEPROM addresses, and exactly len_i of them are delivered.
- R9: At completion, done_o pulses for one cycle. At that point count_o equals the number of bytes delivered and err_o tells whether the transfer aborted. Both values hold until the next accepted start.
- R10: A start with len_i = 0 completes with done_o, count_o = 0 and err_o = 0, and causes no bus activity.
- R11: start_i is ignored while busy_o is high.
- R12: After reset, both line enables are low, and busy_o, done_o, data_valid_o, err_o and count_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a read transfer (sampled while idle) |
| addr_i | input | 11 | First EEPROM address |
| len_i | input | LEN_W | Number of bytes to read |
| sda_i | input | 1 | Sampled level of the data line |
| scl_oe_o | output | 1 | Pull clock line low when 1 |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| busy_o | output | 1 | Transfer in progress |
| data_o | output | 8 | Last received byte |
| data_valid_o | output | 1 | One-cycle strobe for data_o |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last transfer aborted on a missing acknowledge |
| count_o | output | LEN_W | Bytes delivered by the last transfer |

## Verification
The bench builds the block with UNIT_CLKS = 2 and ACK_POLLS = 8. This keeps each transfer to a few hundred cycles, so every value of the upper address bits can be swept against several low-byte patterns and lengths of one to three bytes. A behavioural EEPROM model on the open-drain lines checks the select and address bytes and counts starts, stops and master acknowledges. Under the same settings, the model can withhold the acknowledge at each of the three header bytes, a read can wrap across the top of the address space, and line hold times can be measured cycle by cycle against the unit rules.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  localparam int ADDR_W = 11;
  localparam logic [7:0] SEL_BASE = 8'hA0;

  typedef enum logic [4:0] {
    ST_IDLE, ST_STA_A, ST_STA_B, ST_WR_PRE, ST_WR_LO, ST_WR_HI, ST_WR_END,
    ST_ACK_REL, ST_ACK_HI, ST_ACK_POLL, ST_ACK_LO, ST_RD_HI, ST_RD_LO,
    ST_MA_LO, ST_MA_HI, ST_MA_END, ST_MA_REL, ST_SP_A, ST_SP_B, ST_SP_C,
    ST_DONE
  } step_e;

  typedef enum logic [1:0] {TX_SELW, TX_ADDR, TX_SELR} txb_e;

  // hold length in units for a line transition
  function automatic logic [1:0] hold_units(logic scl_old, logic scl_new,
                                            logic sda_old, logic sda_new);
    if (!scl_old && scl_new) return 2'd2;
    if ((scl_old != scl_new) || (sda_old != sda_new)) return 2'd1;
    return 2'd0;
  endfunction

endpackage

// File: rtl/eeprom_rd_timer.sv
module eeprom_rd_timer #(
  parameter int UNIT_CLKS = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] units_i,
  output logic       expired_o
);
  localparam int MAXC = 2 * UNIT_CLKS;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) begin
      case (units_i)
        2'd2:    cnt_q <= CW'(MAXC);
        2'd1:    cnt_q <= CW'(UNIT_CLKS);
        default: cnt_q <= '0;
      endcase
    end else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0) && !load_i;

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAXC));

endmodule

// File: rtl/eeprom_rd_ackpoll.sv
module eeprom_rd_ackpoll #(
  parameter int POLLS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam int CW = $clog2(POLLS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i && !last_o) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(POLLS - 1));

  assert_poll_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(POLLS - 1));

endmodule

// File: rtl/eeprom_rd_shift.sv
module eeprom_rd_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (load_i) q_o <= val_i;
    else if (shift_i) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/eeprom_rd_master.sv
module eeprom_rd_master
  import eeprom_rd_pkg::*;
#(
  parameter int UNIT_CLKS = 100,   // 1 us at 100 MHz
  parameter int ACK_POLLS = 1000,
  parameter int LEN_W     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic [7:0]        data_o,
  output logic              data_valid_o,
  output logic              done_o,
  output logic              err_o,
  output logic [LEN_W-1:0]  count_o
);
  localparam int HW = $clog2(2 * UNIT_CLKS + 4);

  step_e             st_q;
  txb_e              txb_q;
  logic              apply_q, sda_q, scl_q, nack_q;
  logic [2:0]        bit_q;
  logic [LEN_W-1:0]  remain_q, count_q;
  logic              err_q, done_q, valid_q;
  logic [7:0]        data_q;
  logic [ADDR_W-1:0] addr_q;

  logic       sda_t, scl_t, expired, advance, poll_last;
  logic [1:0] units;
  logic [7:0] sh_q, sh_val;
  logic       sh_load, sh_shift;

  // target line levels per step (1 = released)
  always_comb begin
    sda_t = sda_q;
    scl_t = scl_q;
    unique case (st_q)
      ST_STA_A:   begin sda_t = 1'b1;     scl_t = 1'b1; end
      ST_STA_B:   begin sda_t = 1'b0;     scl_t = 1'b1; end
      ST_WR_PRE:  begin sda_t = 1'b0;     scl_t = 1'b0; end
      ST_WR_LO:   begin sda_t = sh_q[7];  scl_t = 1'b0; end
      ST_WR_HI:   begin sda_t = sh_q[7];  scl_t = 1'b1; end
      ST_WR_END:  begin                   scl_t = 1'b0; end
      ST_ACK_REL: begin sda_t = 1'b1;     scl_t = 1'b0; end
      ST_ACK_HI:  begin sda_t = 1'b1;     scl_t = 1'b1; end
      ST_ACK_LO:  begin sda_t = 1'b1;     scl_t = 1'b0; end
      ST_RD_HI:   begin sda_t = 1'b1;     scl_t = 1'b1; end
      ST_RD_LO:   begin sda_t = 1'b1;     scl_t = 1'b0; end
      ST_MA_LO:   begin sda_t = 1'b0;     scl_t = 1'b0; end
      ST_MA_HI:   begin sda_t = 1'b0;     scl_t = 1'b1; end
      ST_MA_END:  begin sda_t = 1'b0;     scl_t = 1'b0; end
      ST_MA_REL:  begin sda_t = 1'b1;     scl_t = 1'b0; end
      ST_SP_A:    begin sda_t = 1'b0;     scl_t = 1'b0; end
      ST_SP_B:    begin sda_t = 1'b0;     scl_t = 1'b1; end
      ST_SP_C:    begin sda_t = 1'b1;     scl_t = 1'b1; end
      default:    ;
    endcase
  end

  assign units = hold_units(scl_q, scl_t, sda_q, sda_t);

  eeprom_rd_timer #(.UNIT_CLKS(UNIT_CLKS)) u_timer (
    .clk_i, .rst_ni, .load_i(apply_q), .units_i(units), .expired_o(expired)
  );

  assign advance = !apply_q && expired;

  eeprom_rd_ackpoll #(.POLLS(ACK_POLLS)) u_poll (
    .clk_i, .rst_ni,
    .clr_i(advance && st_q == ST_ACK_HI),
    .en_i(!apply_q && st_q == ST_ACK_POLL),
    .last_o(poll_last)
  );

  always_comb begin
    unique case (txb_q)
      TX_SELW: sh_val = SEL_BASE | {4'b0, addr_q[10:8], 1'b0};
      TX_ADDR: sh_val = addr_q[7:0];
      default: sh_val = SEL_BASE | {4'b0, addr_q[10:8], 1'b1};
    endcase
  end

  assign sh_load  = advance && st_q == ST_WR_PRE;
  assign sh_shift = advance && ((st_q == ST_WR_HI && bit_q != 3'd7) || st_q == ST_RD_HI);

  eeprom_rd_shift #(.W(8)) u_shift (
    .clk_i, .rst_ni, .load_i(sh_load), .val_i(sh_val),
    .shift_i(sh_shift), .bit_i(sda_i), .q_o(sh_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  apply_q <= 1'b0;  sda_q <= 1'b1;  scl_q <= 1'b1;
      txb_q <= TX_SELW; bit_q <= '0;      remain_q <= '0; count_q <= '0;
      err_q <= 1'b0;    done_q <= 1'b0;   valid_q <= 1'b0; nack_q <= 1'b0;
      data_q <= '0;     addr_q <= '0;
    end else begin
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      if (apply_q) begin
        sda_q   <= sda_t;
        scl_q   <= scl_t;
        apply_q <= 1'b0;
      end else if (expired) begin
        unique case (st_q)
          ST_IDLE: if (start_i) begin
            addr_q   <= addr_i;
            remain_q <= len_i;
            count_q  <= '0;
            err_q    <= 1'b0;
            txb_q    <= TX_SELW;
            st_q     <= (len_i == '0) ? ST_DONE : ST_STA_A;
            apply_q  <= 1'b1;
          end
          ST_STA_A:   begin st_q <= ST_STA_B;   apply_q <= 1'b1; end
          ST_STA_B:   begin st_q <= ST_WR_PRE;  apply_q <= 1'b1; end
          ST_WR_PRE:  begin st_q <= ST_WR_LO;   bit_q <= '0; apply_q <= 1'b1; end
          ST_WR_LO:   begin st_q <= ST_WR_HI;   apply_q <= 1'b1; end
          ST_WR_HI: begin
            if (bit_q == 3'd7) st_q <= ST_WR_END;
            else begin bit_q <= bit_q + 1'b1; st_q <= ST_WR_LO; end
            apply_q <= 1'b1;
          end
          ST_WR_END:  begin st_q <= ST_ACK_REL; apply_q <= 1'b1; end
          ST_ACK_REL: begin st_q <= ST_ACK_HI;  apply_q <= 1'b1; end
          ST_ACK_HI:  st_q <= ST_ACK_POLL;
          ST_ACK_POLL: begin
            if (!sda_i) begin
              nack_q <= 1'b0; st_q <= ST_ACK_LO; apply_q <= 1'b1;
            end else if (poll_last) begin
              nack_q <= 1'b1; st_q <= ST_ACK_LO; apply_q <= 1'b1;
            end
          end
          ST_ACK_LO: begin
            apply_q <= 1'b1;
            if (nack_q) begin
              err_q <= 1'b1;
              st_q  <= ST_SP_A;
            end else begin
              unique case (txb_q)
                TX_SELW: begin txb_q <= TX_ADDR; st_q <= ST_WR_PRE; end
                TX_ADDR: begin txb_q <= TX_SELR; st_q <= ST_STA_A;  end
                default: begin bit_q <= '0;      st_q <= ST_RD_HI;  end
              endcase
            end
          end
          ST_RD_HI: begin
            if (bit_q == 3'd7) begin
              data_q   <= {sh_q[6:0], sda_i};
              valid_q  <= 1'b1;
              count_q  <= count_q + 1'b1;
              remain_q <= remain_q - 1'b1;
            end
            st_q    <= ST_RD_LO;
            apply_q <= 1'b1;
          end
          ST_RD_LO: begin
            if (bit_q == 3'd7) begin
              bit_q <= '0;
              st_q  <= (remain_q == '0) ? ST_SP_A : ST_MA_LO;
            end else begin
              bit_q <= bit_q + 1'b1;
              st_q  <= ST_RD_HI;
            end
            apply_q <= 1'b1;
          end
          ST_MA_LO:  begin st_q <= ST_MA_HI;  apply_q <= 1'b1; end
          ST_MA_HI:  begin st_q <= ST_MA_END; apply_q <= 1'b1; end
          ST_MA_END: begin st_q <= ST_MA_REL; apply_q <= 1'b1; end
          ST_MA_REL: begin st_q <= ST_RD_HI;  apply_q <= 1'b1; end
          ST_SP_A:   begin st_q <= ST_SP_B;   apply_q <= 1'b1; end
          ST_SP_B:   begin st_q <= ST_SP_C;   apply_q <= 1'b1; end
          ST_SP_C:   begin st_q <= ST_DONE;   apply_q <= 1'b1; end
          ST_DONE:   begin done_q <= 1'b1;    st_q <= ST_IDLE; end
          default:   st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign scl_oe_o     = !scl_q;
  assign sda_oe_o     = !sda_q;
  assign busy_o       = (st_q != ST_IDLE);
  assign data_o       = data_q;
  assign data_valid_o = valid_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign count_o      = count_q;

  // hold-time tracking for line changes
  logic          chg;
  logic [HW-1:0] hold_q, need_q;

  assign chg = apply_q && ((sda_t != sda_q) || (scl_t != scl_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '1;
      need_q <= '0;
    end else if (chg) begin
      hold_q <= '0;
      need_q <= (!scl_q && scl_t) ? HW'(2 * UNIT_CLKS) : HW'(UNIT_CLKS);
    end else if (hold_q != '1) begin
      hold_q <= hold_q + 1'b1;
    end
  end

  assert_hold_time_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |-> hold_q >= need_q);

  assert_sda_only_clock_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_q && $past(scl_q) && (sda_q != $past(sda_q))) |->
      ($past(st_q) == ST_STA_B || $past(st_q) == ST_SP_C));

  assert_valid_in_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> busy_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_no_bytes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (count_o == '0));

  assert_idle_released_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));

endmodule

// File: tb/eeprom_rd_master_tb_top.sv
module eeprom_rd_master_tb_top;
  localparam int U  = 2;
  localparam int P  = 8;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start_i = 1'b0;
  logic [10:0]   addr_i = '0;
  logic [LW-1:0] len_i = '0;
  logic          scl_oe, sda_oe, busy, dvalid, done, err;
  logic [7:0]    data;
  logic [LW-1:0] count;
  logic          s_oe = 1'b0;
  logic          scl_line, sda_line;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe | s_oe);

  eeprom_rd_master #(.UNIT_CLKS(U), .ACK_POLLS(P), .LEN_W(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .addr_i(addr_i),
    .len_i(len_i), .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .busy_o(busy), .data_o(data), .data_valid_o(dvalid), .done_o(done),
    .err_o(err), .count_o(count)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_f(logic [10:0] a);
    int v;
    v = int'(a) * 37 + int'(a >> 8) * 11 + 5;
    return v[7:0];
  endfunction

  // ---------------- EEPROM model ----------------
  int mode = 0, bitc = 0, tbit = 0, hdr_idx = 0, nack_at = -1, rxack_ph = 0;
  int n_start = 0, n_stop = 0, n_mack = 0;
  logic [7:0]  sh = '0, txb = '0, cap_selw = '0, cap_addr = '0, cap_selr = '0;
  logic [10:0] ptr = '0;
  logic [2:0]  hi = '0;
  logic expect_sel = 1'b0, rd_next = 1'b0, ack_pend = 1'b0, mack_s = 1'b0;
  logic p_scl = 1'b1, p_sda = 1'b1;

  always @(scl_line or sda_line) begin
    if (scl_line && p_scl && (sda_line != p_sda)) begin
      if (!sda_line) begin
        n_start++; mode = 1; bitc = 0; expect_sel = 1'b1; s_oe = 1'b0;
      end else begin
        n_stop++; mode = 0; s_oe = 1'b0;
      end
    end else if (scl_line && !p_scl) begin
      if (mode == 1) begin
        sh = {sh[6:0], sda_line};
        bitc++;
        if (bitc == 8) begin
          bitc = 0; mode = 2; rxack_ph = 0; rd_next = 1'b0;
          ack_pend = (hdr_idx != nack_at);
          if (expect_sel) begin
            expect_sel = 1'b0;
            if (!sh[0]) begin cap_selw = sh; hi = sh[3:1]; end
            else begin cap_selr = sh; rd_next = 1'b1; end
          end else if (hdr_idx == 1) begin
            cap_addr = sh; ptr = {hi, sh};
          end
          hdr_idx++;
        end
      end else if (mode == 4) begin
        mack_s = !sda_line;
      end
    end else if (!scl_line && p_scl) begin
      if (mode == 2) begin
        if (rxack_ph == 0) begin
          s_oe = ack_pend; rxack_ph = 1;
        end else begin
          s_oe = 1'b0;
          if (rd_next && ack_pend) begin
            mode = 3; txb = mem_f(ptr); tbit = 7; s_oe = !txb[7];
          end else if (ack_pend) mode = 1;
          else mode = 0;
        end
      end else if (mode == 3) begin
        if (tbit == 0) begin s_oe = 1'b0; mode = 4; mack_s = 1'b0; end
        else begin tbit--; s_oe = !txb[tbit]; end
      end else if (mode == 4) begin
        if (mack_s) begin
          n_mack++; ptr = ptr + 1'b1; txb = mem_f(ptr); tbit = 7;
          s_oe = !txb[7]; mode = 3;
        end else begin
          mode = 0; s_oe = 1'b0;
        end
      end
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  // ---------------- monitor ----------------
  int cyc = 0, hold = 1000, need = 0, viol = 0, n_chg = 0, n_rx = 0, n_done = 0, d_cnt = 0;
  logic d_err = 1'b0;
  logic [1:0] prev_l = 2'b11;
  logic [7:0] rx [0:63];
  bit finished = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if ({!scl_oe, !sda_oe} != prev_l) begin
        n_chg++;
        if (hold < need * U) viol++;
        need = (!prev_l[1] && !scl_oe) ? 2 : 1;
        hold = 1;
        prev_l = {!scl_oe, !sda_oe};
      end else if (hold < 1000) hold++;
      if (dvalid) begin
        if (n_rx < 64) rx[n_rx] = data;
        n_rx++;
      end
      if (done) begin
        n_done++; d_err = err; d_cnt = int'(count);
      end
    end
    if (cyc > 190000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run(int a, int len, int nk, bit poke);
    int w;
    logic [7:0] sel;
    n_start = 0; n_stop = 0; n_mack = 0; hdr_idx = 0; nack_at = nk;
    n_rx = 0; n_done = 0; viol = 0; n_chg = 0; mode = 0;
    cap_selw = '0; cap_addr = '0; cap_selr = '0;
    @(negedge clk);
    addr_i = 11'(a); len_i = LW'(len); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (200) @(negedge clk);
      addr_i = ~addr_i; len_i = LW'(1); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    w = 0;
    while (n_done == 0 && w < 20000) begin
      @(negedge clk);
      w++;
    end
    repeat (6) @(negedge clk);
    check(n_done == 1, "R9", "done pulses", n_done, 1);
    check(!busy, "R11", "busy after done", int'(busy), 0);
    sel = 8'hA0 | {4'b0, 3'(a >> 8), 1'b0};
    if (len == 0) begin
      check(d_cnt == 0 && !d_err, "R10", "count/err for zero length", d_cnt, 0);
      check(n_chg == 0, "R10", "line changes for zero length", n_chg, 0);
    end else if (nk >= 0) begin
      check(d_err, "R5", "err on missing ack", int'(d_err), 1);
      check(d_cnt == 0 && n_rx == 0, "R5", "bytes after abort", n_rx, 0);
      check(n_stop == 1, "R1", "stop after abort", n_stop, 1);
      check(n_start == ((nk == 2) ? 2 : 1), "R3", "starts before abort", n_start,
            (nk == 2) ? 2 : 1);
    end else begin
      check(cap_selw == sel, "R2", "write select byte", int'(cap_selw), int'(sel));
      check(cap_selr == (sel | 8'h01), "R2", "read select byte", int'(cap_selr),
            int'(sel | 8'h01));
      check(cap_addr == 8'(a), "R3", "address byte", int'(cap_addr), a & 255);
      check(n_start == 2, "R3", "start count", n_start, 2);
      check(n_stop == 1, "R1", "stop count", n_stop, 1);
      check(n_rx == len, "R8", "bytes delivered", n_rx, len);
      for (int i = 0; i < len && i < 64; i++)
        check(rx[i] == mem_f(11'(a + i)), "R4", "data byte (MSB first)",
              int'(rx[i]), int'(mem_f(11'(a + i))));
      check(n_mack == len - 1, "R6", "master acks", n_mack, len - 1);
      check(d_cnt == len && !d_err, "R9", "final count", d_cnt, len);
      check(count == LW'(len) && !err, "R9", "count held", int'(count), len);
      check(viol == 0, "R7", "hold violations", viol, 0);
    end
  endtask

  initial begin
    int lo_pat [3];
    lo_pat[0] = 8'h00; lo_pat[1] = 8'h5A; lo_pat[2] = 8'hFF;
    repeat (4) @(negedge clk);
    check(!scl_oe && !sda_oe, "R12", "line enables in reset", int'({scl_oe, sda_oe}), 0);
    check(!busy && !done && !dvalid && !err && count == '0, "R12", "status in reset",
          int'({busy, done, dvalid, err}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !scl_oe && !sda_oe, "R12", "idle after reset", int'(busy), 0);

    for (int h = 0; h < 8; h++)
      for (int l = 0; l < 3; l++)
        for (int n = 1; n <= 3; n++)
          run(h * 256 + lo_pat[l], n, -1, 1'b0);

    run(2046, 4, -1, 1'b0);        // wrap across top of address space
    run(960, 6, -1, 1'b1);         // R11: start pulse while busy
    run(300, 2, 0, 1'b0);          // R5: no ack on write select
    run(1500, 2, 1, 1'b0);         // R5: no ack on address
    run(77, 2, 2, 1'b0);           // R5: no ack on read select
    check(err && count == '0, "R9", "error held until next start", int'(err), 1);
    run(500, 0, -1, 1'b0);         // R10
    run(1234, 3, -1, 1'b0);        // recovery after abort

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule